// File: doc/BRIEF.md
# Transceiver Quad Reset Sequencer

This block brings the shared resources of a four-lane serial transceiver quad out of reset in a fixed order. The resources are two PLLs, an internal oscillator, the TX and RX rate dividers, and the TX and RX channels. Five request inputs each pick a subset of that order. The sequencer pulses one resource reset at a time. After each pulse it waits for that resource's ready or lock input before it moves on. It reports a done flag for each data direction and an error flag when a resource never becomes ready.

A master enable input selects between two modes. When it is high, the automatic sequencer runs. When it is low, each resource reset follows the request levels directly, with no ordering. A request that arrives while a sequence is running is held and serviced once that sequence ends. The ready inputs stand in for analog lock and calibration status.

Top module: `quad_rst_seq`

## Requirements
- R1: While `rstN` is low, and after it rises with no request, every bit of `resRst` is 0 and `txDone`, `rxDone` and `seqErr` are 0.
- R2: Resource bit positions are 0 LC PLL, 1 ring PLL, 2 oscillator, 3 TX divider, 4 RX divider, 5 TX channel, 6 RX channel. With `masterEn` high, at most one `resRst` bit is high at a time. Selected resources are pulsed in rising bit order, and unselected resources are skipped.
- R3: `reqGlobal` selects all seven resources.
- R4: `reqTxPll` selects bits 0, 3 and 5. `reqRxPll` selects bits 1, 4 and 6.
- R5: `reqTxPath` selects bits 3 and 5 only. `reqRxPath` selects bits 4 and 6 only. Neither touches a PLL.
- R6: Each reset pulse lasts exactly `HOLD_CYC` cycles. The next pulse starts only after `resRdy` of the released resource is high.
- R7: A sequence that selects bit 5 clears `txDone` when it starts, and one that selects bit 6 clears `rxDone`. Each flag is set when its channel step completes. A sequence that does not select a direction's channel leaves that direction's flag unchanged.
- R8: If `resRdy` stays low for `TIMEOUT_CYC` cycles after a release, `seqErr` is set, the remaining steps are dropped, and `txDone`/`rxDone` stay as they are. `seqErr` is cleared when the next sequence starts.
- R9: A request counts on its rising edge. Requests that rise during a sequence are held and run after it ends. A held `reqGlobal` wins and runs the full sequence. Several held non-global requests merge into one sequence.
- R10: With `masterEn` low, `resRst` bit i is high while any request whose set contains i is high. `txDone` equals `resRdy[5]` when `resRst[5]` is low and 0 otherwise, and `rxDone` is formed the same way from bit 6. Requests seen in this mode are discarded and do not start a sequence later.
- R11: A `reqTxPll` sequence followed later by a separate `reqRxPath` sequence each completes on its own. `txDone` stays high through the second sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| masterEn | input | 1 | 1: automatic sequencing, 0: direct pass-through |
| reqGlobal | input | 1 | Full-quad reset request |
| reqTxPll | input | 1 | TX direction plus its PLL |
| reqRxPll | input | 1 | RX direction plus its PLL |
| reqTxPath | input | 1 | TX divider and channel only |
| reqRxPath | input | 1 | RX divider and channel only |
| resRdy | input | 7 | Per-resource ready/lock, bit order as R2 |
| resRst | output | 7 | Per-resource reset, bit order as R2 |
| txDone | output | 1 | TX direction out of reset |
| rxDone | output | 1 | RX direction out of reset |
| seqErr | output | 1 | Last sequence timed out |

## Verification
A wrong step index or mask shows up on `resRst` as a wrong bit in the very cycle after the request edge is taken, or after the previous ready. The bench logs the order of rising resets and compares it against the expected subset. A hold counter that is off by one shows as a pulse width other than `HOLD_CYC` when the first reset drops. A sequencer that advances without waiting for ready shows as a gap shorter than the ready latency. A lost held request shows as a missing second run within a few dozen cycles. A flag updated on the wrong event shows on `txDone`, `rxDone` or `seqErr` at the sampling point right after the sequence starts or ends.

// File: rtl/qrs_pkg.sv
package qrs_pkg;
  localparam int NUM_RES = 7;
  localparam int NUM_REQ = 5;

  // resource bit positions (sequence order)
  localparam int IDX_LCPLL = 0;
  localparam int IDX_RPLL  = 1;
  localparam int IDX_OSC   = 2;
  localparam int IDX_TXDIV = 3;
  localparam int IDX_RXDIV = 4;
  localparam int IDX_TXCH  = 5;
  localparam int IDX_RXCH  = 6;

  // request bit positions
  localparam int REQ_GLB   = 0;
  localparam int REQ_TXPLL = 1;
  localparam int REQ_RXPLL = 2;
  localparam int REQ_TXDP  = 3;
  localparam int REQ_RXDP  = 4;

  localparam logic [NUM_RES-1:0] MASK_TXDP  = NUM_RES'(1 << IDX_TXDIV) | NUM_RES'(1 << IDX_TXCH);
  localparam logic [NUM_RES-1:0] MASK_RXDP  = NUM_RES'(1 << IDX_RXDIV) | NUM_RES'(1 << IDX_RXCH);
  localparam logic [NUM_RES-1:0] MASK_TXPLL = MASK_TXDP | NUM_RES'(1 << IDX_LCPLL);
  localparam logic [NUM_RES-1:0] MASK_RXPLL = MASK_RXDP | NUM_RES'(1 << IDX_RPLL);

  typedef enum logic [1:0] {S_IDLE, S_ASSERT, S_WAIT} seqState_t;

  typedef struct packed {
    logic startSeq;
    logic cntClr;
    logic txFin;
    logic rxFin;
    logic timeout;
  } seqStb_t;

  function automatic logic [NUM_RES-1:0] coverMask(input logic [NUM_REQ-1:0] r);
    logic [NUM_RES-1:0] m;
    m = '0;
    if (r[REQ_TXPLL]) m = m | MASK_TXPLL;
    if (r[REQ_RXPLL]) m = m | MASK_RXPLL;
    if (r[REQ_TXDP])  m = m | MASK_TXDP;
    if (r[REQ_RXDP])  m = m | MASK_RXDP;
    if (r[REQ_GLB])   m = '1;
    return m;
  endfunction
endpackage

// File: rtl/qrs_dp.sv
module qrs_dp
  import qrs_pkg::*;
#(
  parameter int HOLD_CYC    = 4,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               masterEn,
  input  logic [NUM_REQ-1:0] reqVec,
  input  seqStb_t            stb,
  output logic [NUM_RES-1:0] selMask,
  output logic               holdDone,
  output logic               toExpired,
  output logic               txDoneQ,
  output logic               rxDoneQ,
  output logic               errQ
);
  localparam int CNT_MAX = (TIMEOUT_CYC > HOLD_CYC) ? TIMEOUT_CYC : HOLD_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [NUM_REQ-1:0] reqQ, pendQ, pendAll;
  logic [CNT_W-1:0]   cnt;

  assign pendAll   = pendQ | (reqVec & ~reqQ);
  assign selMask   = masterEn ? coverMask(pendAll) : '0;
  assign holdDone  = (cnt == CNT_W'(HOLD_CYC - 1));
  assign toExpired = (cnt == CNT_W'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ    <= '0;
      pendQ   <= '0;
      cnt     <= '0;
      txDoneQ <= 1'b0;
      rxDoneQ <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      reqQ <= reqVec;
      if (!masterEn || stb.startSeq) pendQ <= '0;
      else                           pendQ <= pendAll;
      cnt <= stb.cntClr ? '0 : cnt + 1'b1;
      if (stb.startSeq) begin
        if (selMask[IDX_TXCH]) txDoneQ <= 1'b0;
        if (selMask[IDX_RXCH]) rxDoneQ <= 1'b0;
        errQ <= 1'b0;
      end
      if (stb.txFin)   txDoneQ <= 1'b1;
      if (stb.rxFin)   rxDoneQ <= 1'b1;
      if (stb.timeout) errQ    <= 1'b1;
    end
  end

  // R7
  tx_done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txDoneQ) |-> $past(stb.txFin));
  // R7
  rx_done_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxDoneQ) |-> $past(stb.rxFin));
  // R8
  err_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errQ) |-> $past(stb.timeout));
  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.startSeq |=> (pendQ == '0));
endmodule

// File: rtl/qrs_ctrl.sv
module qrs_ctrl
  import qrs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               masterEn,
  input  logic [NUM_RES-1:0] selMask,
  input  logic               holdDone,
  input  logic               toExpired,
  input  logic [NUM_RES-1:0] resRdy,
  output seqStb_t            stb,
  output logic [NUM_RES-1:0] seqRst
);
  seqState_t          stateQ, stateD;
  logic [2:0]         stepQ, stepD;
  logic [NUM_RES-1:0] maskQ, maskD;
  logic [3:0]         firstHit, nextHit;

  // returns {found, index} of the lowest set bit above 'from'
  function automatic logic [3:0] lowestAbove(input logic [NUM_RES-1:0] m, input int from);
    logic [3:0] r;
    r = 4'b0;
    for (int i = NUM_RES - 1; i >= 0; i--)
      if (m[i] && i > from) r = {1'b1, 3'(i)};
    return r;
  endfunction

  assign firstHit = lowestAbove(selMask, -1);
  assign nextHit  = lowestAbove(maskQ, int'(stepQ));

  always_comb begin
    stb    = '0;
    stateD = stateQ;
    stepD  = stepQ;
    maskD  = maskQ;
    case (stateQ)
      S_IDLE: if (masterEn && (|selMask)) begin
        stb.startSeq = 1'b1;
        stb.cntClr   = 1'b1;
        maskD        = selMask;
        stepD        = firstHit[2:0];
        stateD       = S_ASSERT;
      end
      S_ASSERT: begin
        if (!masterEn) stateD = S_IDLE;
        else if (holdDone) begin
          stateD     = S_WAIT;
          stb.cntClr = 1'b1;
        end
      end
      S_WAIT: begin
        if (!masterEn) stateD = S_IDLE;
        else if (resRdy[stepQ]) begin
          stb.txFin = (int'(stepQ) == IDX_TXCH);
          stb.rxFin = (int'(stepQ) == IDX_RXCH);
          if (nextHit[3]) begin
            stepD      = nextHit[2:0];
            stateD     = S_ASSERT;
            stb.cntClr = 1'b1;
          end else begin
            stateD = S_IDLE;
          end
        end else if (toExpired) begin
          stb.timeout = 1'b1;
          stateD      = S_IDLE;
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      stepQ  <= '0;
      maskQ  <= '0;
    end else begin
      stateQ <= stateD;
      stepQ  <= stepD;
      maskQ  <= maskD;
    end
  end

  assign seqRst = (stateQ == S_ASSERT) ? (NUM_RES'(1) << stepQ) : '0;

  // R2
  step_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_WAIT && stateD == S_ASSERT) |=> (stepQ > $past(stepQ)));
  // R6
  wait_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_WAIT && masterEn && !resRdy[stepQ] && !toExpired) |=> (stateQ == S_WAIT));
  // R6
  hold_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_ASSERT && masterEn && !holdDone) |=> (stateQ == S_ASSERT));
endmodule

// File: rtl/quad_rst_seq.sv
module quad_rst_seq
  import qrs_pkg::*;
#(
  parameter int HOLD_CYC    = 4,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       masterEn,
  input  logic       reqGlobal,
  input  logic       reqTxPll,
  input  logic       reqRxPll,
  input  logic       reqTxPath,
  input  logic       reqRxPath,
  input  logic [6:0] resRdy,
  output logic [6:0] resRst,
  output logic       txDone,
  output logic       rxDone,
  output logic       seqErr
);
  logic [NUM_REQ-1:0] reqVec;
  logic [NUM_RES-1:0] selMask, seqRst, directMask;
  logic               holdDone, toExpired, txDoneQ, rxDoneQ;
  seqStb_t            stb;

  assign reqVec     = {reqRxPath, reqTxPath, reqRxPll, reqTxPll, reqGlobal};
  assign directMask = coverMask(reqVec);

  qrs_dp #(.HOLD_CYC(HOLD_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) dp_i (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .reqVec(reqVec), .stb(stb),
    .selMask(selMask), .holdDone(holdDone), .toExpired(toExpired),
    .txDoneQ(txDoneQ), .rxDoneQ(rxDoneQ), .errQ(seqErr)
  );

  qrs_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .selMask(selMask),
    .holdDone(holdDone), .toExpired(toExpired), .resRdy(resRdy),
    .stb(stb), .seqRst(seqRst)
  );

  assign resRst = masterEn ? seqRst : directMask;
  assign txDone = masterEn ? txDoneQ : (resRdy[IDX_TXCH] & ~directMask[IDX_TXCH]);
  assign rxDone = masterEn ? rxDoneQ : (resRdy[IDX_RXCH] & ~directMask[IDX_RXCH]);

  // R2
  one_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    masterEn |-> $onehot0(resRst));
  // R10
  bypass_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!masterEn && reqGlobal) |-> (resRst == '1));
endmodule

// File: tb/quad_rst_seq_tb_top.sv
`timescale 1ns/1ps
module quad_rst_seq_tb_top;
  localparam int HOLD = 4;
  localparam int TOUT = 64;
  localparam int LAT  = 3;

  logic clk = 1'b0, rstN = 1'b0, masterEn = 1'b1;
  logic reqGlobal = 0, reqTxPll = 0, reqRxPll = 0, reqTxPath = 0, reqRxPath = 0;
  logic [6:0] resRdy = '0, stuck = '0, resRst;
  logic txDone, rxDone, seqErr;

  int nChk = 0, nBad = 0;
  int logN = 0, cyc = 0, lastFall = 0;
  longint logCode = 0;
  int widthBad = 0, gapBad = 0, overlapBad = 0;
  int wcnt [7];
  int lc [7];
  logic [6:0] prevRst = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  quad_rst_seq #(.HOLD_CYC(HOLD), .TIMEOUT_CYC(TOUT)) dut_i (
    .clk(clk), .rstN(rstN), .masterEn(masterEn), .reqGlobal(reqGlobal),
    .reqTxPll(reqTxPll), .reqRxPll(reqRxPll), .reqTxPath(reqTxPath),
    .reqRxPath(reqRxPath), .resRdy(resRdy), .resRst(resRst),
    .txDone(txDone), .rxDone(rxDone), .seqErr(seqErr)
  );

  // ready/lock stub: low while in reset, high LAT+1 cycles after release
  always @(posedge clk) begin
    for (int i = 0; i < 7; i++) begin
      if (resRst[i] || stuck[i] || !rstN) begin
        resRdy[i] <= 1'b0;
        lc[i]     <= 0;
      end else if (lc[i] < LAT) lc[i] <= lc[i] + 1;
      else resRdy[i] <= 1'b1;
    end
  end

  // monitor: order, pulse widths, gaps, overlap
  always @(posedge clk) begin
    #1;
    cyc++;
    if (masterEn && $countones(resRst) > 1) overlapBad++;
    for (int i = 0; i < 7; i++) begin
      if (resRst[i] && !prevRst[i]) begin
        if (masterEn && logN > 0 && (cyc - lastFall) < LAT) gapBad++;
        logCode = logCode * 10 + (i + 1);
        logN++;
        wcnt[i] = 1;
      end else if (resRst[i]) wcnt[i]++;
      else if (prevRst[i]) begin
        if (masterEn && wcnt[i] != HOLD) widthBad++;
        lastFall = cyc;
      end
    end
    prevRst = resRst;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clrLog();
    logN = 0;
    logCode = 0;
  endtask

  task automatic pulse(ref logic r);
    @(negedge clk); r = 1'b1;
    @(negedge clk); r = 1'b0;
  endtask

  task automatic waitQuiet();
    int q = 0;
    while (q < 12) begin
      @(negedge clk);
      if (resRst == '0) q++; else q = 0;
    end
  endtask

  task automatic t_reset();
    repeat (10) @(negedge clk);
    chk(resRst == 0 && !txDone && !rxDone && !seqErr, "R1 in reset", {resRst, txDone, rxDone, seqErr}, 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    chk(resRst == 0 && !txDone && !rxDone && !seqErr, "R1 idle after reset", {resRst, txDone, rxDone, seqErr}, 0);
  endtask

  task automatic t_global();
    clrLog();
    pulse(reqGlobal);
    chk(!txDone && !rxDone, "R7 both cleared at global start", {txDone, rxDone}, 0);
    waitQuiet();
    chk(logCode == 1234567, "R3 R2 global order", logCode, 1234567);
    chk(txDone && rxDone, "R7 both done after global", {txDone, rxDone}, 3);
  endtask

  task automatic t_txpll_then_rxpath();
    clrLog();
    pulse(reqTxPll);
    chk(!txDone && rxDone, "R7 tx cleared rx kept", {txDone, rxDone}, 1);
    waitQuiet();
    chk(logCode == 146, "R4 tx pll order", logCode, 146);
    chk(txDone, "R11 tx done after first", txDone, 1);
    clrLog();
    pulse(reqRxPath);
    chk(txDone && !rxDone, "R7 rx cleared tx kept", {txDone, rxDone}, 2);
    waitQuiet();
    chk(logCode == 57, "R5 rx path order", logCode, 57);
    chk(txDone && rxDone, "R11 both done after second", {txDone, rxDone}, 3);
  endtask

  task automatic t_rxpll_txpath();
    clrLog();
    pulse(reqRxPll);
    waitQuiet();
    chk(logCode == 257, "R4 rx pll order", logCode, 257);
    clrLog();
    pulse(reqTxPath);
    waitQuiet();
    chk(logCode == 46, "R5 tx path order", logCode, 46);
    chk(txDone && rxDone, "R7 flags after path resets", {txDone, rxDone}, 3);
  endtask

  task automatic t_pending();
    clrLog();
    pulse(reqTxPll);
    pulse(reqRxPath);
    pulse(reqGlobal);
    waitQuiet();
    chk(logCode == 1461234567, "R9 global wins held", logCode, 1461234567);
    clrLog();
    pulse(reqTxPath);
    pulse(reqRxPath);
    pulse(reqRxPll);
    waitQuiet();
    chk(logCode == 46257, "R9 held requests merged", logCode, 46257);
  endtask

  task automatic t_timeout();
    stuck[3] = 1'b1;
    clrLog();
    pulse(reqTxPath);
    repeat (120) @(negedge clk);
    chk(seqErr && !txDone && rxDone, "R8 timeout flags", {seqErr, txDone, rxDone}, 5);
    chk(logCode == 4, "R8 remaining steps dropped", logCode, 4);
    stuck[3] = 1'b0;
    clrLog();
    pulse(reqTxPath);
    chk(!seqErr, "R8 error cleared at start", seqErr, 0);
    waitQuiet();
    chk(logCode == 46 && txDone && !seqErr, "R8 recovery", logCode, 46);
  endtask

  task automatic t_bypass();
    @(negedge clk); masterEn = 1'b0; reqTxPath = 1'b1;
    #1 chk(resRst == 7'h28 && !txDone, "R10 tx path direct", resRst, 7'h28);
    @(negedge clk); reqTxPath = 1'b0; reqGlobal = 1'b1;
    #1 chk(resRst == 7'h7F, "R10 global direct", resRst, 7'h7F);
    @(negedge clk); reqGlobal = 1'b0;
    #1 chk(resRst == 7'h00, "R10 released", resRst, 0);
    repeat (8) @(negedge clk);
    chk(txDone && rxDone, "R10 done follows ready", {txDone, rxDone}, 3);
    pulse(reqRxPll);
    @(negedge clk); masterEn = 1'b1;
    clrLog();
    repeat (20) @(negedge clk);
    chk(logN == 0 && resRst == 0, "R10 bypass request discarded", logCode, 0);
  endtask

  initial begin
    t_reset();
    t_global();
    t_txpll_then_rxpath();
    t_rxpll_txpath();
    t_pending();
    t_timeout();
    t_bypass();
    chk(widthBad == 0, "R6 pulse width", widthBad, 0);
    chk(gapBad == 0, "R6 wait for ready", gapBad, 0);
    chk(overlapBad == 0, "R2 one reset at a time", overlapBad, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule